// File: doc/BRIEF.md
# Two-Stage DMA Channel Trigger Router

This block sits beside a bank of independent DMA channels and lets one channel's completion start another channel in hardware, with no software step in between. Every channel holds a small configuration: a role (not chained, source of a group, or destination of a group) and a trigger level (fragment, block, transfer or link-list completion). Software loads that configuration by writing a packed 32-bit flags word into one or more channels at once.

Two independent chaining groups exist. When a source channel of a group reports the completion level chosen by that group's destination, the router issues a single-cycle start pulse to the destination channel. Each group also has a configuration-error flag. The flag is raised when the group does not have exactly one destination, or when its setup holds an out-of-range code. While the flag is raised, the group issues no start pulses.

Top module: `dma_chain_router`

## Requirements
- R1: On a clock edge where `cfg_we[i]` is high, channel i takes its role from `cfg_flags[26:24]` and its trigger level from `cfg_flags[18:16]`. All other bits of the word are ignored, several channels may be written by one write, and channels whose `cfg_we` bit is low keep their setup.
- R2: Role codes are 0 = not chained, 1 = group 0 source, 2 = group 1 source, 3 = group 0 destination and 4 = group 1 destination. Trigger codes are 0 = none, 1 = fragment done, 2 = block done, 3 = transfer done and 4 = link-list done. The destination of a group starts when any source of the same group pulses the done input that matches the destination's trigger code.
- R3: A start pulse is one clock wide. It is visible on `start_o` in the cycle after the edge that samples the done input, and it returns low when that done input is no longer high.
- R4: The two groups are independent. A source of group 0 never starts the destination of group 1, and the reverse also holds. Both groups may fire in the same cycle.
- R5: Done inputs of a level other than the destination's selected trigger level start nothing.
- R6: A channel with role 0 never starts and never triggers anything. A destination with trigger code 0 never starts. A channel that is not a destination never receives a start pulse.
- R7: `cfg_err[g]` is high while the number of group g destinations is not exactly one. While it is high, group g issues no start.
- R8: A role code of 5 to 7 in any channel raises both `cfg_err` bits. A trigger code of 5 to 7 in the destination of group g raises `cfg_err[g]` only. Either case blocks the affected group's starts.
- R9: After reset every channel has role 0 and trigger 0, `start_o` is all zero and `cfg_err` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | NCH | Per-channel write enable for the flags word |
| cfg_flags | input | 32 | Packed configuration word (role at 26:24, trigger at 18:16) |
| frag_done | input | NCH | Per-channel fragment completion pulse |
| blk_done | input | NCH | Per-channel block completion pulse |
| xfer_done | input | NCH | Per-channel transfer completion pulse |
| list_done | input | NCH | Per-channel link-list completion pulse |
| start_o | output | NCH | Per-channel start pulse to the channel's data mover |
| cfg_err | output | 2 | Per-group configuration-error flag |

## Verification
The bench builds the router with NCH = 6. That gives room for one source and one destination in each group, plus two spare channels. The spare channels are used to add a second destination to a group, to hold an unchained channel that still gets done pulses, and to carry an out-of-range role code. With six channels, a single write can hit several channels at once, and every trigger level can be tried against a live pair while the other group keeps running.

// File: rtl/dma_chain_router.sv
module dma_chain_router #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cfg_we,
  input  logic [31:0]    cfg_flags,
  input  logic [NCH-1:0] frag_done,
  input  logic [NCH-1:0] blk_done,
  input  logic [NCH-1:0] xfer_done,
  input  logic [NCH-1:0] list_done,
  output logic [NCH-1:0] start_o,
  output logic [1:0]     cfg_err
);
  localparam int ROLE_LSB = 24;
  localparam int TRIG_LSB = 16;
  localparam int FW       = 3;
  localparam int NGRP     = 2;
  localparam logic [FW-1:0] CODE_MAX = 3'd4;

  logic [NCH-1:0][FW-1:0] role_q, trig_q;
  logic [NCH-1:0]         start_q;
  logic [NCH-1:0]         role_bad, trig_bad;
  logic [NGRP-1:0][NCH-1:0] src_m, dst_m;
  logic [NGRP-1:0][3:0]   grp_ev;
  logic [NGRP-1:0]        grp_err;
  logic [NCH-1:0]         fire;

  logic unused_flag_bits;
  assign unused_flag_bits = ^{cfg_flags[31:27], cfg_flags[23:19], cfg_flags[15:0]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        role_q[i] <= '0;
        trig_q[i] <= '0;
      end else if (cfg_we[i]) begin
        role_q[i] <= cfg_flags[ROLE_LSB +: FW];
        trig_q[i] <= cfg_flags[TRIG_LSB +: FW];
      end
    end
    assign role_bad[i] = role_q[i] > CODE_MAX;
    assign trig_bad[i] = trig_q[i] > CODE_MAX;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar i = 0; i < NCH; i++) begin : g_m
      assign src_m[g][i] = role_q[i] == FW'(1 + g);
      assign dst_m[g][i] = role_q[i] == FW'(3 + g);
    end
    assign grp_ev[g][0] = |(frag_done & src_m[g]);
    assign grp_ev[g][1] = |(blk_done  & src_m[g]);
    assign grp_ev[g][2] = |(xfer_done & src_m[g]);
    assign grp_ev[g][3] = |(list_done & src_m[g]);
    assign grp_err[g]   = !$onehot(dst_m[g]) || (|role_bad) || (|(dst_m[g] & trig_bad));
  end

  always_comb begin
    fire = '0;
    for (int i = 0; i < NCH; i++) begin
      for (int g = 0; g < NGRP; g++) begin
        if (dst_m[g][i] && !grp_err[g]) begin
          case (trig_q[i])
            3'd1: fire[i] = grp_ev[g][0];
            3'd2: fire[i] = grp_ev[g][1];
            3'd3: fire[i] = grp_ev[g][2];
            3'd4: fire[i] = grp_ev[g][3];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else        start_q <= fire;
  end

  assign start_o = start_q;
  assign cfg_err = grp_err;
endmodule

// File: rtl/dma_chain_router_chk.sv
module dma_chain_router_chk #(
  parameter int NCH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      frag_done,
  input logic [NCH-1:0]      blk_done,
  input logic [NCH-1:0]      xfer_done,
  input logic [NCH-1:0]      list_done,
  input logic [NCH-1:0]      start_o,
  input logic [1:0]          cfg_err,
  input logic [NCH-1:0][2:0] role_q
);
  logic any_done;
  assign any_done = |{frag_done, blk_done, xfer_done, list_done};

  a_r2_start_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_o) |-> $past(any_done));

  a_r3_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !any_done |=> (start_o == '0));

  a_r4_one_per_group: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(start_o) <= 2);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r6_dest_only: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[i] |-> ($past(role_q[i]) == 3'd3 || $past(role_q[i]) == 3'd4));

    a_r7_err_blocks_g0: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o[i] && $past(role_q[i]) == 3'd3) |-> !$past(cfg_err[0]));

    a_r7_err_blocks_g1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o[i] && $past(role_q[i]) == 3'd4) |-> !$past(cfg_err[1]));
  end
endmodule

bind dma_chain_router dma_chain_router_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frag_done(frag_done), .blk_done(blk_done),
  .xfer_done(xfer_done), .list_done(list_done), .start_o(start_o),
  .cfg_err(cfg_err), .role_q(role_q)
);

// File: tb/tb_dma_chain_router.sv
`timescale 1ns/1ps
module tb_dma_chain_router;
  localparam int NCH = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] cfg_we = '0;
  logic [31:0]    cfg_flags = '0;
  logic [NCH-1:0] frag_done = '0, blk_done = '0, xfer_done = '0, list_done = '0;
  logic [NCH-1:0] start_o;
  logic [1:0]     cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_chain_router #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flags(cfg_flags),
    .frag_done(frag_done), .blk_done(blk_done), .xfer_done(xfer_done),
    .list_done(list_done), .start_o(start_o), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_start(input string req, input logic [NCH-1:0] exp);
    check(start_o == exp, req, int'(start_o), int'(exp));
  endtask

  task automatic chk_err(input string req, input logic [1:0] exp);
    check(cfg_err == exp, req, int'(cfg_err), int'(exp));
  endtask

  function automatic logic [31:0] mk(input logic [2:0] role, input logic [2:0] trig);
    return {5'b10101, role, 5'b11011, trig, 16'h5A3C};
  endfunction

  task automatic wr(input logic [NCH-1:0] mask, input logic [2:0] role, input logic [2:0] trig);
    @(negedge clk);
    cfg_we = mask;
    cfg_flags = mk(role, trig);
    @(negedge clk);
    cfg_we = '0;
    cfg_flags = '1;
  endtask

  task automatic pulse(input int lvl, input logic [NCH-1:0] ch);
    @(negedge clk);
    case (lvl)
      1: frag_done = ch;
      2: blk_done  = ch;
      3: xfer_done = ch;
      default: list_done = ch;
    endcase
    @(negedge clk);
    frag_done = '0; blk_done = '0; xfer_done = '0; list_done = '0;
  endtask

  task automatic pulse_all(input logic [NCH-1:0] ch);
    @(negedge clk);
    frag_done = ch; blk_done = ch; xfer_done = ch; list_done = ch;
    @(negedge clk);
    frag_done = '0; blk_done = '0; xfer_done = '0; list_done = '0;
  endtask

  task automatic t_reset;
    chk_start("R9 start after reset", '0);
    chk_err("R9 err after reset", 2'b11);
  endtask

  task automatic t_load;
    wr(6'b000001, 3'd1, 3'd0);
    wr(6'b000010, 3'd3, 3'd2);
    chk_err("R1 group0 formed", 2'b10);
    wr(6'b000100, 3'd2, 3'd0);
    wr(6'b001000, 3'd4, 3'd3);
    chk_err("R1 both groups formed", 2'b00);
  endtask

  task automatic t_levels;
    for (int t = 1; t <= 4; t++) begin
      wr(6'b000010, 3'd3, 3'(t));
      pulse(t, 6'b000001);
      chk_start("R2 selected level starts dest", 6'b000010);
      @(negedge clk);
      chk_start("R3 pulse one cycle", '0);
      pulse((t % 4) + 1, 6'b000001);
      chk_start("R5 other level ignored", '0);
    end
    wr(6'b000010, 3'd3, 3'd2);
  endtask

  task automatic t_groups;
    @(negedge clk);
    blk_done = 6'b000001; xfer_done = 6'b000100;
    @(negedge clk);
    blk_done = '0; xfer_done = '0;
    chk_start("R4 both groups fire together", 6'b001010);
    pulse(3, 6'b000001);
    chk_start("R4 group0 source cannot start group1", '0);
    pulse(2, 6'b000100);
    chk_start("R4 group1 source cannot start group0", '0);
  endtask

  task automatic t_idle;
    wr(6'b000010, 3'd3, 3'd0);
    chk_err("R6 zero trigger is not an error", 2'b00);
    pulse_all(6'b000001);
    chk_start("R6 trigger zero never starts", '0);
    wr(6'b000010, 3'd3, 3'd2);
    wr(6'b010000, 3'd0, 3'd1);
    pulse_all(6'b010000);
    chk_start("R6 role zero ignored", '0);
    pulse_all(6'b000001);
    chk_start("R6 source itself never starts", 6'b000010);
  endtask

  task automatic t_dest_count;
    wr(6'b100000, 3'd3, 3'd2);
    chk_err("R7 two destinations", 2'b01);
    pulse(2, 6'b000001);
    chk_start("R7 blocked with two destinations", '0);
    pulse(3, 6'b000100);
    chk_start("R7 other group unaffected", 6'b001000);
    wr(6'b100010, 3'd0, 3'd0);
    chk_err("R7 no destination", 2'b01);
    pulse_all(6'b000001);
    chk_start("R7 blocked with no destination", '0);
    wr(6'b000010, 3'd3, 3'd2);
    chk_err("R1 restored after write", 2'b00);
  endtask

  task automatic t_bad_codes;
    wr(6'b010000, 3'd6, 3'd0);
    chk_err("R8 bad role raises both", 2'b11);
    pulse(2, 6'b000001);
    chk_start("R8 bad role blocks group0", '0);
    wr(6'b010000, 3'd0, 3'd0);
    chk_err("R8 cleared", 2'b00);
    wr(6'b001000, 3'd4, 3'd5);
    chk_err("R8 bad dest trigger only its group", 2'b10);
    pulse_all(6'b000101);
    chk_start("R8 group1 blocked, group0 runs", 6'b000010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_levels();
    t_groups();
    t_idle();
    t_dest_count();
    t_bad_codes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule